// File: doc/BRIEF.md
# LED Sequencer Configuration Write Target (I2C)

This block is the write-only configuration port of an RGB LED sequencer. It watches a two-wire I2C bus in fast mode, sampling SCL and SDA with a much faster system clock, and recognises START and STOP conditions. It also recognises its own 7-bit target address, which a strap input picks from a pair. After the address it takes a register pointer byte and then any number of data bytes. Each data byte is stored in a bank of 22 byte-wide control registers, and the pointer then advances by itself.

The register bank is presented to the sequencer as one flat vector. Each register keeps only the bits that carry meaning, and every other bit stays at zero. Bit 0 of register 00h is a soft reset. Setting it empties the whole bank, and the bit then clears itself. The active-low reset input empties the bank as well. The block never reads, never stretches the clock and answers no 10-bit addressing.

Top module: `ledcfg_i2c_target`

## Requirements
- R1: The target address is 7'b0011010 when `addr_sel` is 0 and 7'b0011011 when it is 1. An address byte that carries this address with R/W = 0 is acknowledged: `sda_pull` goes high during the ninth SCL clock so that the bus reads low at that clock's rising edge.
- R2: A START is SDA falling while SCL is high, and a STOP is SDA rising while SCL is high. A START, whether after a STOP or repeated, always restarts at the address byte. A STOP part-way through a byte writes nothing.
- R3: `sda_pull` rises only while SCL is low. It is released after the falling edge of the ninth clock, so it is low during every data bit.
- R4: An address byte with R/W = 1, or one that carries a different address, is not acknowledged. No later byte is acknowledged until the next START, and no register changes.
- R5: The first byte after an acknowledged address sets the pointer. Each later byte is stored at the pointer, and the pointer then moves to pointer+1. Registers change only through such a write, a soft reset or `rst_n`.
- R6: A byte stored at pointer 15h moves the pointer to 00h, so the next byte lands in register 00h.
- R7: Stored values are the written byte ANDed with a per-register mask. Register 00h uses 31h, 01h uses 77h, and 02h and 0Ch use F7h. Registers 05h, 08h, 0Bh, 0Fh, 12h and 15h use 0Fh. All the others use 7Fh.
- R8: Bytes written at pointers 16h and above are acknowledged, but no register changes.
- R9: While `rst_n` is low, every register reads 0 and `sda_pull` is 0.
- R10: If a write leaves bit 0 of register 00h set, all registers, bit 0 included, read 0 two clock cycles later.
- R11: SCL and SDA pass through a two-flop synchroniser. A level change is accepted only after two consistent samples, so a one-sample SCL glitch has no effect on the received data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low reset, clears all registers |
| addr_sel | input | 1 | Strap that selects the low address bit |
| scl_in | input | 1 | I2C clock line as seen at the pin |
| sda_in | input | 1 | I2C data line as seen at the pin |
| sda_pull | output | 1 | 1 pulls SDA low (open-drain enable) |
| cfg_regs | output | 176 | Register n at bits [8n+7:8n] |

## Verification
The hardest state to reach from the ports is the wrap of the pointer from 15h to 00h in the middle of a burst. This is most dangerous when the bytes that follow the wrap land in register 00h, where bit 0 can empty the whole bank. The bench runs one burst through all 22 registers and beyond, and then a sweep of short bursts from every start pointer. The value for register 00h is chosen so that the wrap is visible without setting the soft reset, and a separate write sets that bit on purpose. A one-sample SCL glitch inside a data bit and a STOP cut into the middle of a byte cover the edge filter and the framing.

// File: rtl/ledcfg_pkg.sv
package ledcfg_pkg;

  typedef enum logic [1:0] {
    ENG_IDLE,
    ENG_RX,
    ENG_ACK,
    ENG_SKIP
  } eng_state_t;

  // Target address: upper six bits from the base, lowest bit from the strap.
  function automatic logic [6:0] target_addr(input logic [6:0] base, input logic sel);
    return {base[6:1], sel};
  endfunction

  // Pointer advance with wrap from the last register to zero.
  function automatic logic [7:0] next_ptr(input logic [7:0] p, input logic [7:0] last);
    return (p == last) ? 8'h00 : p + 8'h01;
  endfunction

  // Bits that carry meaning in each register; everything else is stored as 0.
  function automatic logic [7:0] field_mask(input logic [7:0] a);
    logic [7:0] rel;
    logic [7:0] m;
    rel = 8'h00;
    if (a == 8'd0)                    m = 8'h31;
    else if (a == 8'd1)               m = 8'h77;
    else if (a == 8'd2 || a == 8'd12) m = 8'hF7;
    else begin
      rel = (a < 8'd12) ? a - 8'd3 : a - 8'd13;
      m   = ((rel % 8'd3) == 8'd2) ? 8'h0F : 8'h7F;
    end
    return m;
  endfunction

endpackage

// File: rtl/ledcfg_line_filter.sv
module ledcfg_line_filter #(
  parameter int   STAGES   = 2,
  parameter logic IDLE_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic level
);

  logic [STAGES-1:0] sync_q;
  logic              agree;

  assign agree = (sync_q[STAGES-1] == sync_q[STAGES-2]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_q <= {STAGES{IDLE_VAL}};
      level  <= IDLE_VAL;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], pin};
      if (agree) level <= sync_q[STAGES-1];
    end
  end

endmodule

// File: rtl/ledcfg_wr_engine.sv
module ledcfg_wr_engine
  import ledcfg_pkg::*;
#(
  parameter int         NUM_REGS  = 22,
  parameter logic [6:0] BASE_ADDR = 7'h1A
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       addr_sel,
  input  logic       scl_f,
  input  logic       sda_f,
  output logic       sda_pull,
  output logic       wr_en,
  output logic [7:0] wr_addr,
  output logic [7:0] wr_data
);

  localparam logic [7:0] LAST_PTR = 8'(NUM_REGS - 1);
  localparam logic [7:0] PTR_END  = 8'(NUM_REGS);

  eng_state_t state;
  logic [2:0] bit_cnt;
  logic [6:0] shreg;
  logic       addr_phase;
  logic       ptr_valid;
  logic       ack_pend;
  logic [7:0] ptr;
  logic       scl_d, sda_d;

  // named internal events
  logic       scl_rise, scl_fall, start_det, stop_det, byte_done, addr_ok;
  logic [7:0] rx_byte;

  assign scl_rise  = scl_f & ~scl_d;
  assign scl_fall  = ~scl_f & scl_d;
  assign start_det = scl_f & scl_d & sda_d & ~sda_f;
  assign stop_det  = scl_f & scl_d & ~sda_d & sda_f;
  assign rx_byte   = {shreg, sda_f};
  assign byte_done = (state == ENG_RX) && scl_rise && (bit_cnt == 3'd7) && !ack_pend;
  assign addr_ok   = (rx_byte[7:1] == target_addr(BASE_ADDR, addr_sel)) && !rx_byte[0];

  assign wr_en   = byte_done && !addr_phase && ptr_valid && (ptr < PTR_END);
  assign wr_addr = ptr;
  assign wr_data = rx_byte;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl_f;
      sda_d <= sda_f;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ENG_IDLE;
      bit_cnt    <= 3'd0;
      shreg      <= 7'd0;
      addr_phase <= 1'b1;
      ptr_valid  <= 1'b0;
      ack_pend   <= 1'b0;
      ptr        <= 8'h00;
      sda_pull   <= 1'b0;
    end else if (start_det) begin
      state      <= ENG_RX;
      bit_cnt    <= 3'd0;
      addr_phase <= 1'b1;
      ptr_valid  <= 1'b0;
      ack_pend   <= 1'b0;
      sda_pull   <= 1'b0;
    end else if (stop_det) begin
      state    <= ENG_IDLE;
      ack_pend <= 1'b0;
      sda_pull <= 1'b0;
    end else begin
      case (state)
        ENG_RX: begin
          if (scl_rise && !ack_pend) begin
            shreg   <= rx_byte[6:0];
            bit_cnt <= bit_cnt + 3'd1;
          end
          if (byte_done) begin
            if (addr_phase) begin
              addr_phase <= 1'b0;
              if (addr_ok) ack_pend <= 1'b1;
              else         state    <= ENG_SKIP;
            end else begin
              ack_pend <= 1'b1;
              if (!ptr_valid) begin
                ptr       <= rx_byte;
                ptr_valid <= 1'b1;
              end else begin
                ptr <= next_ptr(ptr, LAST_PTR);
              end
            end
          end
          if (ack_pend && scl_fall) begin
            sda_pull <= 1'b1;
            ack_pend <= 1'b0;
            state    <= ENG_ACK;
          end
        end
        ENG_ACK: begin
          if (scl_fall) begin
            sda_pull <= 1'b0;
            state    <= ENG_RX;
          end
        end
        default: ;
      endcase
    end
  end

  // R3: the acknowledge is raised only while the clock is low
  assert_ack_rise_scl_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_pull) |-> !scl_f);

  // R4: a rejected transfer never drives the bus
  assert_skip_silent_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ENG_SKIP) |-> !sda_pull);

  // R6: a write at the last register wraps the pointer to zero
  assert_ptr_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && ptr == LAST_PTR && !start_det && !stop_det) |=> (ptr == 8'h00));

endmodule

// File: rtl/ledcfg_regfile.sv
module ledcfg_regfile
  import ledcfg_pkg::*;
#(
  parameter int NUM_REGS = 22
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [7:0]            wr_addr,
  input  logic [7:0]            wr_data,
  output logic [NUM_REGS*8-1:0] cfg_flat
);

  logic [7:0] q [NUM_REGS];
  logic       soft_clr;

  assign soft_clr = q[0][0];

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    localparam logic [7:0] IDX  = 8'(i);
    localparam logic [7:0] MASK = field_mask(IDX);

    always_ff @(posedge clk) begin
      if (!rst_n)                        q[i] <= 8'h00;
      else if (soft_clr)                 q[i] <= 8'h00;
      else if (wr_en && wr_addr == IDX)  q[i] <= wr_data & MASK;
    end

    assign cfg_flat[8*i +: 8] = q[i];

    // R7: bits outside the mask never hold a one
    assert_undef_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (q[i] & ~MASK) == 8'h00);
  end

  // R10: the soft-reset bit empties the whole bank one cycle later
  assert_soft_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    soft_clr |=> (cfg_flat == '0));

  // R5: without a write or soft reset the bank holds
  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !soft_clr) |=> $stable(cfg_flat));

endmodule

// File: rtl/ledcfg_i2c_target.sv
module ledcfg_i2c_target #(
  parameter int         NUM_REGS    = 22,
  parameter logic [6:0] BASE_ADDR   = 7'h1A,
  parameter int         SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  addr_sel,
  input  logic                  scl_in,
  input  logic                  sda_in,
  output logic                  sda_pull,
  output logic [NUM_REGS*8-1:0] cfg_regs
);

  logic       scl_f, sda_f;
  logic       wr_en;
  logic [7:0] wr_addr, wr_data;

  ledcfg_line_filter #(.STAGES(SYNC_STAGES), .IDLE_VAL(1'b1)) u_scl_filt (
    .clk(clk), .rst_n(rst_n), .pin(scl_in), .level(scl_f));

  ledcfg_line_filter #(.STAGES(SYNC_STAGES), .IDLE_VAL(1'b1)) u_sda_filt (
    .clk(clk), .rst_n(rst_n), .pin(sda_in), .level(sda_f));

  ledcfg_wr_engine #(.NUM_REGS(NUM_REGS), .BASE_ADDR(BASE_ADDR)) u_engine (
    .clk(clk), .rst_n(rst_n), .addr_sel(addr_sel), .scl_f(scl_f), .sda_f(sda_f),
    .sda_pull(sda_pull), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data));

  ledcfg_regfile #(.NUM_REGS(NUM_REGS)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .cfg_flat(cfg_regs));

  // R9: nothing is stored and the bus is free while reset is held
  assert_reset_clear_R9: assert property (@(posedge clk)
    $past(!rst_n) && !rst_n |-> (cfg_regs == '0) && !sda_pull);

endmodule

// File: tb/ledcfg_i2c_target_bench.sv
module ledcfg_i2c_target_bench;

  localparam int CLK_PERIOD = 10;
  localparam int Q          = 8;
  localparam int NREG       = 22;
  localparam int WATCHDOG   = 190000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic addr_sel = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_pull;
  logic sda_line;
  logic [NREG*8-1:0] cfg;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  logic [7:0] expv [NREG];
  logic [7:0] tx_buf [32];
  int glitch_byte = -1;

  assign sda_line = sda_m & ~sda_pull;

  always #(CLK_PERIOD/2) clk = ~clk;

  ledcfg_i2c_target u_ledcfg_i2c_target (
    .clk(clk), .rst_n(rst_n), .addr_sel(addr_sel), .scl_in(scl_m), .sda_in(sda_line),
    .sda_pull(sda_pull), .cfg_regs(cfg));

  function automatic logic [7:0] keep_bits(input int a);
    case (a)
      0:                    return 8'h31;
      1:                    return 8'h77;
      2, 12:                return 8'hF7;
      5, 8, 11, 15, 18, 21: return 8'h0F;
      default:              return 8'h7F;
    endcase
  endfunction

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic compare_all(input string req);
    for (int i = 0; i < NREG; i++)
      check(cfg[8*i +: 8] === expv[i], req, 32'(cfg[8*i +: 8]), 32'(expv[i]));
  endtask

  task automatic model_clear();
    for (int i = 0; i < NREG; i++) expv[i] = 8'h00;
  endtask

  task automatic send_bit(input logic b, input bit glitch);
    sda_m = b;
    tick(Q);
    scl_m = 1'b1;
    tick(Q);
    if (glitch) begin
      scl_m = 1'b0; tick(1); scl_m = 1'b1; tick(Q - 1);
    end else tick(Q);
    check(sda_pull == 1'b0, "R3 data bit", 32'(sda_pull), 0);
    scl_m = 1'b0;
    tick(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, input bit glitch, output bit ack);
    for (int i = 7; i >= 0; i--) send_bit(b[i], glitch && (i == 3));
    sda_m = 1'b1;
    tick(Q);
    scl_m = 1'b1;
    tick(Q);
    ack = (sda_line == 1'b0);
    tick(Q);
    scl_m = 1'b0;
    tick(Q);
    check(sda_pull == 1'b0, "R3 release", 32'(sda_pull), 0);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; tick(Q);
    scl_m = 1'b1; tick(Q);
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b1; tick(Q);
    sda_m = 1'b1; tick(2*Q);
  endtask

  // tx_buf[0] is the pointer, tx_buf[1..n-1] the data
  task automatic run_txn(input logic [6:0] a7, input logic rw, input int n, input bit do_stop,
                         input string tag);
    bit ack;
    bit want;
    logic [7:0] p;
    logic [7:0] d;
    want = (a7 == {6'b001101, addr_sel}) && (rw == 1'b0);
    bus_start();
    send_byte({a7, rw}, 1'b0, ack);
    check(ack == want, want ? "R1 address ack" : "R4 address nack", 32'(ack), 32'(want));
    p = tx_buf[0];
    for (int k = 0; k < n; k++) begin
      send_byte(tx_buf[k], (k == glitch_byte), ack);
      check(ack == want, tag, 32'(ack), 32'(want));
      if (want && k > 0) begin
        if (p < 8'(NREG)) begin
          d = tx_buf[k] & keep_bits(int'(p));
          expv[p] = d;
          if (p == 8'h00 && d[0]) model_clear();
        end
        p = (p == 8'(NREG - 1)) ? 8'h00 : p + 8'h01;
      end
    end
    if (do_stop) bus_stop();
  endtask

  function automatic logic [7:0] pat(input int i, input int seed);
    logic [7:0] v;
    v = 8'(i * 29 + seed) ^ 8'h5A;
    return v;
  endfunction

  initial begin : watchdog
    for (int c = 0; c < WATCHDOG; c++) begin
      @(posedge clk);
      if (done) disable watchdog;
    end
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=done", WATCHDOG);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    bit ack;
    model_clear();
    tick(5);
    // R9: reset state
    compare_all("R9 reset");
    check(sda_pull == 1'b0, "R9 reset sda", 32'(sda_pull), 0);
    rst_n = 1'b1;
    tick(4);

    // R1/R5/R6/R7: burst through every register and across the wrap
    for (int s = 0; s < 2; s++) begin
      addr_sel = s[0];
      tick(4);
      tx_buf[0] = 8'h00;
      for (int k = 1; k <= NREG + 2; k++) tx_buf[k] = pat(k, s * 77);
      tx_buf[1]        = tx_buf[1] & 8'hFE;
      tx_buf[NREG + 1] = 8'h30;
      run_txn({6'b001101, addr_sel}, 1'b0, NREG + 3, 1'b1, "R5 data ack");
      compare_all("R6 R7 full burst with wrap");
    end

    // R4: wrong address and read direction
    addr_sel = 1'b0;
    tx_buf[0] = 8'h03; tx_buf[1] = 8'h11; tx_buf[2] = 8'h22;
    run_txn(7'h1B, 1'b0, 3, 1'b1, "R4 data nack");
    compare_all("R4 wrong address no change");
    run_txn(7'h1A, 1'b1, 3, 1'b1, "R4 data nack");
    compare_all("R4 read direction no change");
    addr_sel = 1'b1;
    run_txn(7'h1A, 1'b0, 3, 1'b1, "R4 data nack");
    compare_all("R4 strap-mismatched address no change");

    // R5/R6: short bursts from every start pointer
    addr_sel = 1'b0;
    for (int p = 0; p < NREG; p++) begin
      tx_buf[0] = 8'(p);
      for (int k = 1; k <= 3; k++) begin
        tx_buf[k] = pat(p * 3 + k, 13);
        if (((p + k - 1) % NREG) == 0) tx_buf[k] = tx_buf[k] & 8'hFE;
      end
      run_txn(7'h1A, 1'b0, 4, 1'b1, "R5 data ack");
      compare_all("R5 R6 pointer sweep");
    end

    // R8: writes beyond the last register
    tx_buf[0] = 8'h16; tx_buf[1] = 8'hFF; tx_buf[2] = 8'hEE;
    run_txn(7'h1A, 1'b0, 3, 1'b1, "R8 discard ack");
    compare_all("R8 beyond range no change");
    tx_buf[0] = 8'h40; tx_buf[1] = 8'h01;
    run_txn(7'h1A, 1'b0, 2, 1'b1, "R8 discard ack");
    compare_all("R8 far pointer no change");

    // R2: repeated start, then STOP cut into a byte
    tx_buf[0] = 8'h04; tx_buf[1] = 8'h6C;
    run_txn(7'h1A, 1'b0, 2, 1'b0, "R2 data ack");
    tx_buf[0] = 8'h10; tx_buf[1] = 8'h3D;
    run_txn(7'h1A, 1'b0, 2, 1'b1, "R2 repeated start ack");
    compare_all("R2 repeated start writes");
    bus_start();
    send_byte(8'h34, 1'b0, ack);
    check(ack == 1'b1, "R2 address ack", 32'(ack), 1);
    send_byte(8'h07, 1'b0, ack);
    for (int i = 0; i < 4; i++) send_bit(1'b1, 1'b0);
    bus_stop();
    tick(4);
    compare_all("R2 partial byte no write");

    // R11: one-sample SCL glitch inside a data bit
    tx_buf[0] = 8'h09; tx_buf[1] = 8'h5B;
    glitch_byte = 1;
    run_txn(7'h1A, 1'b0, 2, 1'b1, "R11 glitch ack");
    glitch_byte = -1;
    compare_all("R11 glitch ignored");

    // R10: soft reset
    tx_buf[0] = 8'h00; tx_buf[1] = 8'h01;
    run_txn(7'h1A, 1'b0, 2, 1'b1, "R10 data ack");
    compare_all("R10 soft reset clears all");
    check(cfg[0] == 1'b0, "R10 self clear", 32'(cfg[0]), 0);

    // R9: hardware reset in the middle of operation
    tx_buf[0] = 8'h05; tx_buf[1] = 8'hAB; tx_buf[2] = 8'hCD;
    run_txn(7'h1A, 1'b0, 3, 1'b1, "R9 data ack");
    compare_all("R9 preload");
    rst_n = 1'b0;
    tick(3);
    model_clear();
    compare_all("R9 reset mid run");
    rst_n = 1'b1;
    tick(4);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule